// File: doc/BRIEF.md
# Push-Button Volume Offset Controller

This block turns two active-low front-panel buttons into a volume trim. It keeps a 5-bit attenuation offset and a mute flag. It adds the offset to an attenuation value that software writes, which gives the attenuation the output stage actually uses. A button counts as pressed only after it has stayed low for a qualification time. A button that stays held keeps stepping at a fixed repeat cadence. Pressing both buttons together toggles mute.

Both pins pass through a two-flop synchronizer. All press timing is counted in enables from a 1 ms tick input, so the block holds no wall-clock constants. Any qualified single-button step also releases mute. Software can clear mute with a one-cycle strobe. The qualification time (default 50 ticks) and the repeat period (default 200 ticks) are parameters. The repeat period must be longer than the qualification time.

Top module: `vol_button_ctrl`

## Requirements
- R1: `att_total` equals `master_att + att_offset` when that sum fits in ATT_W bits. Otherwise it is all ones. It never wraps.
- R2: When volume-up (`vol_up_n` low) is held alone for QUAL_TICKS ticks, `att_offset` decreases by one. At 0 it stays at 0.
- R3: When volume-down (`vol_dn_n` low) is held alone for QUAL_TICKS ticks, `att_offset` increases by one. At 31 it stays at 31.
- R4: A single-button press released after fewer than QUAL_TICKS ticks leaves `att_offset` and `mute` unchanged.
- R5: A single button held for n ticks, with n >= QUAL_TICKS, gives 1 + floor(n / REPEAT_TICKS) steps in total. Steps fall at tick QUAL_TICKS, then at REPEAT_TICKS and every REPEAT_TICKS after that. The offset changes only on the clock edge that follows a tick.
- R6: If both buttons are low, and the second went low before the first had qualified, `mute` toggles once and `att_offset` does not change. Nothing more happens until both buttons are released, however long they are held.
- R7: A second button pressed after the first has qualified is ignored. The first button keeps its step and repeat timing, and `mute` is not toggled.
- R8: A qualified single-button step clears `mute` in the same edge that applies the step.
- R9: A one-cycle `sw_unmute` pulse clears `mute` on the next edge. It wins over a mute toggle in that same cycle.
- R10: After reset, `att_offset` is 0 and `mute` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle enable every millisecond |
| vol_up_n | input | 1 | Volume-up button, active low, asynchronous |
| vol_dn_n | input | 1 | Volume-down button, active low, asynchronous |
| sw_unmute | input | 1 | Software strobe that clears mute |
| master_att | input | ATT_W (6) | Software master attenuation |
| att_offset | output | OFS_W (5) | Button-controlled attenuation offset |
| mute | output | 1 | Mute flag |
| att_total | output | ATT_W (6) | Saturated sum of master attenuation and offset |

## Verification
The bench uses a small timing configuration: qualification takes 3 ticks and repeat takes 5. It holds each button alone for every length from 0 to 12 ticks. This separates the case with no step, the case with a single step, and the cases where the repeat starts, and so it shows where qualification ends and repeat begins. Long holds drive the offset into both rails to show saturation. The summed output is swept across every master value at offsets 0, 9 and 31, which separates exact sums from clipped ones. Mute is exercised in several ways: a simultaneous press, a long press with both held, a staggered press inside the window, a staggered press after qualification, an unmute by a step, and an unmute by the software strobe.

// File: rtl/vbc_pkg.sv
`timescale 1ns/1ps
// Shared types for the push-button volume offset controller.
package vbc_pkg;

    // Request passed from the press timer to the offset register.
    typedef enum logic [1:0] {
        EV_NONE   = 2'd0,
        EV_LOUDER = 2'd1,
        EV_SOFTER = 2'd2,
        EV_MUTE   = 2'd3
    } vbc_ev_e;

    // Press-timer state.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_HELD = 2'd2,
        ST_BOTH = 2'd3
    } vbc_st_e;

    // Which button a single press belongs to.
    typedef enum logic {
        BTN_UP = 1'b0,
        BTN_DN = 1'b1
    } vbc_btn_e;

endpackage

// File: rtl/vbc_sync.sv
`timescale 1ns/1ps
// Multi-stage flop synchronizer for asynchronous level inputs.
// Assumes: the inputs are slow levels such as buttons, so per-bit
// synchronization is enough. Reset loads RST_VAL into every stage.
module vbc_sync #(
    parameter int          STAGES  = 2,
    parameter int          WIDTH   = 2,
    parameter logic [63:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the asynchronous pins.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL[WIDTH-1:0];
                else        stage_q[g] <= din;
            end
        end else begin : g_next
            // Later stages give metastability time to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= RST_VAL[WIDTH-1:0];
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/vbc_press_fsm.sv
`timescale 1ns/1ps
// Press timer: qualifies single presses, paces auto-repeat and
// detects both-button presses. It emits at most one request per cycle.
// Assumes: synchronized active-high pressed levels, and a tick enable
// that is high for one cycle per millisecond. REPEAT_TICKS must be
// greater than QUAL_TICKS.
module vbc_press_fsm
    import vbc_pkg::*;
#(
    parameter int QUAL_TICKS   = 50,
    parameter int REPEAT_TICKS = 200
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    tick,
    input  logic    up_on,
    input  logic    dn_on,
    output vbc_ev_e ev
);

    localparam int CNT_W = $clog2(REPEAT_TICKS + 1);
    localparam logic [CNT_W-1:0] QUAL_END = CNT_W'(QUAL_TICKS);
    localparam logic [CNT_W-1:0] REP_END  = CNT_W'(REPEAT_TICKS);

    vbc_st_e          st_q, st_d;
    vbc_btn_e         btn_q, btn_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_inc;
    logic             own_on;
    vbc_ev_e          step_ev;

    assign cnt_inc = cnt_q + CNT_W'(1);
    assign own_on  = (btn_q == BTN_UP) ? up_on : dn_on;
    assign step_ev = (btn_q == BTN_UP) ? EV_LOUDER : EV_SOFTER;

    // Next-state, counter and request decode.
    always_comb begin
        st_d  = st_q;
        btn_d = btn_q;
        cnt_d = cnt_q;
        ev    = EV_NONE;
        unique case (st_q)
            ST_IDLE: begin
                if (up_on || dn_on) begin
                    st_d  = ST_QUAL;
                    cnt_d = '0;
                    btn_d = up_on ? BTN_UP : BTN_DN;
                end
            end
            ST_QUAL: begin
                if (up_on && dn_on) begin
                    ev   = EV_MUTE;
                    st_d = ST_BOTH;
                end else if (!own_on) begin
                    st_d = ST_IDLE;
                end else if (tick) begin
                    cnt_d = cnt_inc;
                    if (cnt_inc == QUAL_END) begin
                        ev   = step_ev;
                        st_d = ST_HELD;
                    end
                end
            end
            ST_HELD: begin
                if (!own_on) begin
                    st_d = ST_IDLE;
                end else if (tick) begin
                    if (cnt_inc == REP_END) begin
                        ev    = step_ev;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_inc;
                    end
                end
            end
            ST_BOTH: begin
                if (!up_on && !dn_on) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            btn_q <= BTN_UP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            btn_q <= btn_d;
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/vbc_offset_reg.sv
`timescale 1ns/1ps
// Offset and mute register. It applies the timer's requests with
// saturation at 0 and at the top code, and takes the software unmute.
// Assumes: at most one request per cycle. The software clear overrides
// any mute change in the same cycle.
module vbc_offset_reg
    import vbc_pkg::*;
#(
    parameter int OFS_W   = 5,
    parameter int OFS_RST = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vbc_ev_e          ev,
    input  logic             sw_unmute,
    output logic [OFS_W-1:0] offset,
    output logic             mute
);

    localparam logic [OFS_W-1:0] OFS_MAX = '1;

    logic [OFS_W-1:0] ofs_d;
    logic             mute_d;

    // Next offset and mute from the request.
    always_comb begin
        ofs_d  = offset;
        mute_d = mute;
        unique case (ev)
            EV_LOUDER: begin
                if (offset != '0) ofs_d = offset - OFS_W'(1);
                mute_d = 1'b0;
            end
            EV_SOFTER: begin
                if (offset != OFS_MAX) ofs_d = offset + OFS_W'(1);
                mute_d = 1'b0;
            end
            EV_MUTE: mute_d = !mute;
            default: ;
        endcase
        if (sw_unmute) mute_d = 1'b0;
    end

    // Offset and mute registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset <= OFS_W'(OFS_RST);
            mute   <= 1'b0;
        end else begin
            offset <= ofs_d;
            mute   <= mute_d;
        end
    end

endmodule

// File: rtl/vbc_att_sum.sv
`timescale 1ns/1ps
// Saturating adder for master attenuation plus offset.
// Assumes: OFS_W <= ATT_W. A result that does not fit clips to all ones.
module vbc_att_sum #(
    parameter int ATT_W = 6,
    parameter int OFS_W = 5
) (
    input  logic [ATT_W-1:0] master,
    input  logic [OFS_W-1:0] offset,
    output logic [ATT_W-1:0] total
);

    localparam int PAD = ATT_W + 1 - OFS_W;

    logic [ATT_W:0] raw;

    // Widened add, then clip on carry out.
    always_comb begin
        raw   = {1'b0, master} + {{PAD{1'b0}}, offset};
        total = raw[ATT_W] ? '1 : raw[ATT_W-1:0];
    end

endmodule

// File: rtl/vol_button_ctrl.sv
`timescale 1ns/1ps
// Push-button volume offset controller, top level.
// Synchronizes the two button pins, times the presses, keeps the
// offset and mute state and forms the saturated total attenuation.
// Assumes: tick_1ms is a one-cycle enable, and the buttons are active low.
module vol_button_ctrl
    import vbc_pkg::*;
#(
    parameter int OFS_W        = 5,
    parameter int ATT_W        = 6,
    parameter int SYNC_STAGES  = 2,
    parameter int QUAL_TICKS   = 50,
    parameter int REPEAT_TICKS = 200,
    parameter int OFS_RST      = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_1ms,
    input  logic             vol_up_n,
    input  logic             vol_dn_n,
    input  logic             sw_unmute,
    input  logic [ATT_W-1:0] master_att,
    output logic [OFS_W-1:0] att_offset,
    output logic             mute,
    output logic [ATT_W-1:0] att_total
);

    logic [1:0] pins_sync;
    vbc_ev_e    ev;

    vbc_sync #(
        .STAGES (SYNC_STAGES),
        .WIDTH  (2),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({vol_dn_n, vol_up_n}),
        .dout (pins_sync)
    );

    vbc_press_fsm #(
        .QUAL_TICKS  (QUAL_TICKS),
        .REPEAT_TICKS(REPEAT_TICKS)
    ) u_fsm (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick_1ms),
        .up_on(!pins_sync[0]),
        .dn_on(!pins_sync[1]),
        .ev   (ev)
    );

    vbc_offset_reg #(
        .OFS_W  (OFS_W),
        .OFS_RST(OFS_RST)
    ) u_ofs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .sw_unmute(sw_unmute),
        .offset   (att_offset),
        .mute     (mute)
    );

    vbc_att_sum #(
        .ATT_W(ATT_W),
        .OFS_W(OFS_W)
    ) u_sum (
        .master(master_att),
        .offset(att_offset),
        .total (att_total)
    );

endmodule

// File: rtl/vbc_checks.sv
`timescale 1ns/1ps
// Port-level property checker for vol_button_ctrl, attached by bind.
module vbc_checks #(
    parameter int OFS_W = 5,
    parameter int ATT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_1ms,
    input logic             sw_unmute,
    input logic [ATT_W-1:0] master_att,
    input logic [OFS_W-1:0] att_offset,
    input logic             mute,
    input logic [ATT_W-1:0] att_total
);

    localparam logic [ATT_W:0] TOP = {1'b0, {ATT_W{1'b1}}};

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        att_total >= master_att);

    a_r1_clip: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, master_att} + (ATT_W+1)'(att_offset)) > TOP) |-> (att_total == '1));

    a_r2_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (att_offset == $past(att_offset)) || (att_offset == $past(att_offset) + 1)
        || (att_offset == $past(att_offset) - 1));

    a_r5_step_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (att_offset != $past(att_offset)) |-> $past(tick_1ms));

    a_r8_step_unmutes: assert property (@(posedge clk) disable iff (!rst_n)
        (att_offset != $past(att_offset)) |-> !mute);

    a_r9_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sw_unmute |=> !mute);

endmodule

bind vol_button_ctrl vbc_checks #(
    .OFS_W(OFS_W),
    .ATT_W(ATT_W)
) u_vbc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_1ms  (tick_1ms),
    .sw_unmute (sw_unmute),
    .master_att(master_att),
    .att_offset(att_offset),
    .mute      (mute),
    .att_total (att_total)
);

// File: tb/test_vol_button_ctrl.sv
`timescale 1ns/1ps
module test_vol_button_ctrl;

    localparam int Q  = 3;
    localparam int RP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1ms = 1'b0;
    logic       vol_up_n = 1'b1;
    logic       vol_dn_n = 1'b1;
    logic       sw_unmute = 1'b0;
    logic [5:0] master_att = '0;
    logic [4:0] att_offset;
    logic       mute;
    logic [5:0] att_total;

    int total = 0;
    int fails = 0;
    int m_ofs = 0;
    int m_mute = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vol_button_ctrl #(
        .QUAL_TICKS  (Q),
        .REPEAT_TICKS(RP)
    ) i_vol_button_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms),
        .vol_up_n(vol_up_n), .vol_dn_n(vol_dn_n), .sw_unmute(sw_unmute),
        .master_att(master_att), .att_offset(att_offset), .mute(mute),
        .att_total(att_total)
    );

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1ms = 1'b1; step(1);
            tick_1ms = 1'b0; step(1);
        end
    endtask

    // Hold the given buttons for n ticks, then release.
    task automatic hold(input bit up, input bit dn, input int n);
        vol_up_n = !up; vol_dn_n = !dn;
        step(6);
        ticks(n);
        vol_up_n = 1'b1; vol_dn_n = 1'b1;
        step(6);
    endtask

    // Volume-up first for k ticks, then volume-down too for e ticks.
    task automatic stagger(input int k, input int e);
        vol_up_n = 1'b0;
        step(6);
        ticks(k);
        vol_dn_n = 1'b0;
        step(6);
        ticks(e);
        vol_up_n = 1'b1; vol_dn_n = 1'b1;
        step(6);
    endtask

    function automatic int nsteps(input int n);
        return (n < Q) ? 0 : 1 + n / RP;
    endfunction

    task automatic sum_sweep(input string req);
        for (int mm = 0; mm < 64; mm++) begin
            master_att = 6'(mm);
            #1;
            check(req, int'(att_total), (mm + m_ofs > 63) ? 63 : mm + m_ofs);
        end
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        check("R10 offset", int'(att_offset), 0);
        check("R10 mute", int'(mute), 0);
        sum_sweep("R1 ofs0");

        // Volume-down length sweep (R3, R4, R5).
        for (int n = 0; n <= 12; n++) begin
            hold(1'b0, 1'b1, n);
            m_ofs = m_ofs + nsteps(n);
            if (m_ofs > 31) m_ofs = 31;
            check((n < Q) ? "R4 dn" : ((n >= RP) ? "R5 dn" : "R3 dn"), int'(att_offset), m_ofs);
        end
        // Volume-up length sweep (R2, R4, R5).
        for (int n = 12; n >= 0; n--) begin
            hold(1'b1, 1'b0, n);
            m_ofs = m_ofs - nsteps(n);
            if (m_ofs < 0) m_ofs = 0;
            check((n < Q) ? "R4 up" : ((n >= RP) ? "R5 up" : "R2 up"), int'(att_offset), m_ofs);
        end
        // Rails.
        for (int i = 0; i < 4; i++) hold(1'b0, 1'b1, 40);
        m_ofs = 31;
        check("R3 ceiling", int'(att_offset), 31);
        sum_sweep("R1 ofs31");
        for (int i = 0; i < 4; i++) hold(1'b1, 1'b0, 40);
        m_ofs = 0;
        check("R2 floor", int'(att_offset), 0);
        for (int i = 0; i < 3; i++) hold(1'b0, 1'b1, 12);
        m_ofs = 9;
        check("R5 three per hold", int'(att_offset), 9);
        sum_sweep("R1 ofs9");

        // Mute behaviour.
        hold(1'b1, 1'b1, 0);
        check("R6 both mutes", int'(mute), 1);
        check("R6 offset kept", int'(att_offset), m_ofs);
        hold(1'b1, 1'b1, 12);
        check("R6 long both toggles once", int'(mute), 0);
        check("R6 long both offset kept", int'(att_offset), m_ofs);
        stagger(Q - 1, 0);
        check("R6 staggered in window", int'(mute), 1);
        check("R6 staggered offset kept", int'(att_offset), m_ofs);
        hold(1'b1, 1'b0, Q);
        m_ofs = m_ofs - 1;
        check("R8 up unmutes", int'(mute), 0);
        check("R8 up steps", int'(att_offset), m_ofs);
        hold(1'b1, 1'b1, 0);
        check("R6 mute again", int'(mute), 1);
        hold(1'b0, 1'b1, Q);
        m_ofs = m_ofs + 1;
        check("R8 dn unmutes", int'(mute), 0);
        check("R8 dn steps", int'(att_offset), m_ofs);
        hold(1'b1, 1'b1, 0);
        check("R6 mute third", int'(mute), 1);
        sw_unmute = 1'b1; step(1); sw_unmute = 1'b0; step(1);
        check("R9 software clear", int'(mute), 0);
        check("R9 offset kept", int'(att_offset), m_ofs);
        sw_unmute = 1'b1; step(1); sw_unmute = 1'b0; step(1);
        check("R9 clear when unmuted", int'(mute), 0);
        stagger(Q, RP);
        m_ofs = m_ofs - nsteps(Q + RP);
        check("R7 late second ignored mute", int'(mute), 0);
        check("R7 repeat continues", int'(att_offset), m_ofs);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule